// File: doc/BRIEF.md
# Stepping Motor Pulse Former

This block turns a 32768 Hz clock into the gate controls for a two-terminal bipolar stepping motor. The motor coil sits between two push-pull stages, called A-side (`mot1_*`) and B-side (`mot2_*`). Each stage has a high-side gate (`*_p`) and a low-side gate (`*_n`). Both gates are active high, so a 1 means that device is on. A prescaler divides the clock into a slow tick. At the start of every motor period the block fires one drive pulse whose length is a whole number of ticks. Consecutive pulses reverse the current direction through the coil.

Three select inputs pick the run period, the pulse width and the test period. Each one indexes a fixed list. When `test_req` is high, the block uses the test period in place of the run period and keeps the same pulse width. The selected configuration is captured only at a period boundary, so a pulse that has already started always runs to its full length. A combinational `config_error` flag reports a period and width pair that breaks the spacing rule, and it also reports a select code outside its list. A period that starts with such a configuration stays quiet: it emits no pulse.

All inputs are plain control pins and no data stream crosses the block, so there is no valid/ready handshake.

Top module: `stepper_pulse_former`

## Requirements
- R1: While `rst` is high, and after it until the first pulse begins, both low-side gates are on and both high-side gates are off.
- R2: In run mode the distance between pulse starts is a fixed number of ticks, and one tick is 2^PRESC_LOG2 clocks. The run period is chosen by `run_sel`: 0=32, 1=64, 2=128, 3=512, 4=4096 ticks. At the default prescale these are 125 ms, 250 ms, 500 ms, 2 s and 16 s.
- R3: The pulse length is chosen by `wid_sel`: 0=4, 1=6, 2=8, 3=12 ticks. At the default prescale these are about 15.6, 23.4, 31.25 and 46.9 ms. The high-side gate is on for the pulse length minus one clock, because one clock is spent on the dead-time gap.
- R4: Pulses alternate in direction. The first pulse after reset turns on `mot1_p`, the next one turns on `mot2_p`, and the pattern continues that way.
- R5: During a pulse, the stage that is not driven high keeps its low-side gate on. Between pulses, both low-side gates are on and both high-side gates are off. The two high-side gates are never on together.
- R6: Within one stage, the high-side and low-side gates are never on together. Every change from one gate to the other passes through exactly one clock with both gates off.
- R7: While `test_req` is high, the period is chosen by `tst_sel`: 0=64, 1=128, 2=256 ticks. At the default prescale these are 250 ms, 500 ms and 1 s. The pulse length is unchanged.
- R8: Changes to `run_sel`, `wid_sel`, `tst_sel` or `test_req` are captured only at the next period boundary. A pulse in progress keeps its length, and the period in progress keeps its length.
- R9: `config_error` is high, combinationally, in either of two cases. The first case is an active select code outside its list (`run_sel` above 4, or `tst_sel` above 2 while `test_req` is high). The second case is an active period that is neither greater than 4 times the pulse length nor exactly 2 times the pulse length.
- R10: A period that captured an illegal configuration emits no pulse and does not advance the direction. The next legal pulse is therefore opposite to the last pulse that was actually emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz timebase |
| rst | input | 1 | Synchronous reset, active high |
| run_sel | input | 3 | Run-mode period select |
| wid_sel | input | 2 | Pulse length select |
| tst_sel | input | 2 | Test-mode period select |
| test_req | input | 1 | Motor test request; selects the test period |
| mot1_p | output | 1 | A-side high-side gate, 1 = on |
| mot1_n | output | 1 | A-side low-side gate, 1 = on |
| mot2_p | output | 1 | B-side high-side gate, 1 = on |
| mot2_n | output | 1 | B-side low-side gate, 1 = on |
| config_error | output | 1 | Current selection breaks the legality rule |

## Verification
The pattern of the four gate pins is the only visible form of the internal state. A wrong tick counter or a missed boundary changes the spacing between pulse starts, and this shows on the very next pulse edge. A polarity register that fails to toggle, or toggles on a silent period, puts two consecutive pulses on the same side, so the fault appears within one period. A broken stage sequencer shows within a clock as overlapping gates or a missing dead-time cycle. A capture made at the wrong moment shows as a shortened pulse or an early change of period in the same period where the inputs moved.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int TICK_W = 13;
  typedef logic [TICK_W-1:0] ticks_t;

  function automatic ticks_t run_ticks(input logic [2:0] s);
    case (s)
      3'd0: return ticks_t'(32);
      3'd1: return ticks_t'(64);
      3'd2: return ticks_t'(128);
      3'd3: return ticks_t'(512);
      3'd4: return ticks_t'(4096);
      default: return ticks_t'(32);
    endcase
  endfunction

  function automatic ticks_t test_ticks(input logic [1:0] s);
    case (s)
      2'd0: return ticks_t'(64);
      2'd1: return ticks_t'(128);
      2'd2: return ticks_t'(256);
      default: return ticks_t'(64);
    endcase
  endfunction

  function automatic ticks_t wid_ticks(input logic [1:0] s);
    case (s)
      2'd0: return ticks_t'(4);
      2'd1: return ticks_t'(6);
      2'd2: return ticks_t'(8);
      default: return ticks_t'(12);
    endcase
  endfunction

  function automatic logic spacing_ok(input ticks_t per, input ticks_t wid);
    return (per > (wid << 2)) || (per == (wid << 1));
  endfunction
endpackage

// File: rtl/mtr_prescale.sv
module mtr_prescale #(
  parameter int PRESC_LOG2 = 7
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PRESC_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign tick = &cnt;
endmodule

// File: rtl/mtr_cfg_sel.sv
module mtr_cfg_sel
  import mtr_pkg::*;
(
  input  logic [2:0] run_sel,
  input  logic [1:0] wid_sel,
  input  logic [1:0] tst_sel,
  input  logic       test_req,
  output ticks_t     sel_per,
  output ticks_t     sel_wid,
  output logic       sel_legal
);
  logic code_ok;

  always_comb begin
    sel_wid = wid_ticks(wid_sel);
    if (test_req) begin
      sel_per = test_ticks(tst_sel);
      code_ok = (tst_sel <= 2'd2);
    end else begin
      sel_per = run_ticks(run_sel);
      code_ok = (run_sel <= 3'd4);
    end
    sel_legal = code_ok && spacing_ok(sel_per, sel_wid);
  end
endmodule

// File: rtl/mtr_sequencer.sv
module mtr_sequencer
  import mtr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  ticks_t sel_per,
  input  ticks_t sel_wid,
  input  logic   sel_legal,
  output logic   want_a,
  output logic   want_b
);
  ticks_t tcnt, per_l, wid_l;
  logic   started, legal_l, pol;
  logic   boundary, pulse_on;

  assign boundary = !started || (tcnt == per_l - ticks_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      per_l   <= ticks_t'(32);
      wid_l   <= ticks_t'(4);
      started <= 1'b0;
      legal_l <= 1'b0;
      pol     <= 1'b0;
    end else if (tick) begin
      if (boundary) begin
        tcnt    <= '0;
        started <= 1'b1;
        per_l   <= sel_per;
        wid_l   <= sel_wid;
        legal_l <= sel_legal;
        if (started && legal_l) pol <= ~pol;
      end else begin
        tcnt <= tcnt + ticks_t'(1);
      end
    end
  end

  assign pulse_on = started && legal_l && (tcnt < wid_l);
  assign want_a   = pulse_on && !pol;
  assign want_b   = pulse_on && pol;
endmodule

// File: rtl/mtr_stage.sv
module mtr_stage (
  input  logic clk,
  input  logic rst,
  input  logic want_hi,
  output logic p_on,
  output logic n_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p_on <= 1'b0;
      n_on <= 1'b1;
    end else if (want_hi) begin
      if (n_on) n_on <= 1'b0;
      else      p_on <= 1'b1;
    end else begin
      if (p_on) p_on <= 1'b0;
      else      n_on <= 1'b1;
    end
  end
endmodule

// File: rtl/stepper_pulse_former.sv
module stepper_pulse_former
  import mtr_pkg::*;
#(
  parameter int PRESC_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] run_sel,
  input  logic [1:0] wid_sel,
  input  logic [1:0] tst_sel,
  input  logic       test_req,
  output logic       mot1_p,
  output logic       mot1_n,
  output logic       mot2_p,
  output logic       mot2_n,
  output logic       config_error
);
  localparam int NSTAGE = 2;

  logic   tick, sel_legal;
  ticks_t sel_per, sel_wid;
  logic [NSTAGE-1:0] want, p_g, n_g;

  mtr_prescale #(.PRESC_LOG2(PRESC_LOG2)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  mtr_cfg_sel u_cfg (
    .run_sel(run_sel), .wid_sel(wid_sel), .tst_sel(tst_sel), .test_req(test_req),
    .sel_per(sel_per), .sel_wid(sel_wid), .sel_legal(sel_legal)
  );

  mtr_sequencer u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .sel_per(sel_per), .sel_wid(sel_wid), .sel_legal(sel_legal),
    .want_a(want[0]), .want_b(want[1])
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    mtr_stage u_stg (
      .clk(clk), .rst(rst), .want_hi(want[g]), .p_on(p_g[g]), .n_on(n_g[g])
    );
  end

  assign mot1_p       = p_g[0];
  assign mot1_n       = n_g[0];
  assign mot2_p       = p_g[1];
  assign mot2_n       = n_g[1];
  assign config_error = ~sel_legal;
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker (
  input logic clk,
  input logic rst,
  input logic mot1_p,
  input logic mot1_n,
  input logic mot2_p,
  input logic mot2_n
);
  a_r6_no_overlap_a: assert property (@(posedge clk) disable iff (rst)
    !(mot1_p && mot1_n));
  a_r6_no_overlap_b: assert property (@(posedge clk) disable iff (rst)
    !(mot2_p && mot2_n));
  a_r6_gap_before_p_a: assert property (@(posedge clk) disable iff (rst)
    $rose(mot1_p) |-> !$past(mot1_n));
  a_r6_gap_before_n_a: assert property (@(posedge clk) disable iff (rst)
    $rose(mot1_n) |-> !$past(mot1_p));
  a_r6_gap_before_p_b: assert property (@(posedge clk) disable iff (rst)
    $rose(mot2_p) |-> !$past(mot2_n));
  a_r6_gap_before_n_b: assert property (@(posedge clk) disable iff (rst)
    $rose(mot2_n) |-> !$past(mot2_p));
  a_r5_single_high_side: assert property (@(posedge clk) disable iff (rst)
    !(mot1_p && mot2_p));
  a_r5_return_path_b: assert property (@(posedge clk) disable iff (rst)
    mot1_p |-> mot2_n);
  a_r5_return_path_a: assert property (@(posedge clk) disable iff (rst)
    mot2_p |-> mot1_n);
endmodule

bind stepper_pulse_former mtr_checker u_chk (
  .clk(clk), .rst(rst),
  .mot1_p(mot1_p), .mot1_n(mot1_n), .mot2_p(mot2_p), .mot2_n(mot2_n)
);

// File: tb/sim_stepper_pulse_former.sv
module sim_stepper_pulse_former;
  localparam int PL = 2;
  localparam int TK = 1 << PL;

  logic clk = 0, rst = 1;
  logic [2:0] run_sel = 0;
  logic [1:0] wid_sel = 0, tst_sel = 0;
  logic test_req = 0;
  logic mot1_p, mot1_n, mot2_p, mot2_n, config_error;
  int total = 0, bad = 0, cyc = 0;

  stepper_pulse_former #(.PRESC_LOG2(PL)) u0 (
    .clk(clk), .rst(rst), .run_sel(run_sel), .wid_sel(wid_sel), .tst_sel(tst_sel),
    .test_req(test_req), .mot1_p(mot1_p), .mot1_n(mot1_n), .mot2_p(mot2_p),
    .mot2_n(mot2_n), .config_error(config_error)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for a pulse start; side 1 = A-side, 2 = B-side, 0 = none within limit
  task automatic wait_rise(input int limit, output int side, output int t);
    side = 0; t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (mot1_p || mot2_p) begin
        side = mot1_p ? 1 : 2; t = cyc; return;
      end
    end
  endtask

  // counts high-side on time and checks the return path while on (R5)
  task automatic measure(input int side, output int len);
    int path_bad = 0;
    len = 1;
    if (side == 1 && !(mot2_n && !mot1_n)) path_bad++;
    if (side == 2 && !(mot1_n && !mot2_n)) path_bad++;
    forever begin
      @(negedge clk);
      if (!(side == 1 ? mot1_p : mot2_p)) break;
      len++;
    end
    chk("R5 return path during pulse", path_bad, 0);
  endtask

  task automatic pulse(output int side, output int t, output int len);
    wait_rise(20000, side, t);
    if (side == 0) begin len = 0; return; end
    measure(side, len);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset gates", {mot1_p, mot1_n, mot2_p, mot2_n}, 4'b0101);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {mot1_p, mot1_n, mot2_p, mot2_n}, 4'b0101);
  endtask

  task automatic t_basic();
    int s0, t0, l0, s1, t1, l1, s2, t2, l2;
    pulse(s0, t0, l0); pulse(s1, t1, l1); pulse(s2, t2, l2);
    chk("R4 first pulse on A-side", s0, 1);
    chk("R4 second pulse on B-side", s1, 2);
    chk("R4 third pulse on A-side", s2, 1);
    chk("R3 width sel0", l1, 4 * TK - 1);
    chk("R2 period sel0", t1 - t0, 32 * TK);
    chk("R2 period sel0 again", t2 - t1, 32 * TK);
    repeat (10) @(negedge clk);
    chk("R5 idle between pulses", {mot1_p, mot1_n, mot2_p, mot2_n}, 4'b0101);
  endtask

  task automatic t_cfg(input string tag, input logic tr, input logic [2:0] rs,
                       input logic [1:0] ts, input logic [1:0] ws,
                       input int exp_per, input int exp_w);
    int s0, t0, l0, s1, t1, l1;
    test_req = tr; run_sel = rs; tst_sel = ts; wid_sel = ws;
    pulse(s0, t0, l0); pulse(s0, t0, l0); pulse(s1, t1, l1);
    chk({tag, " period"}, t1 - t0, exp_per * TK);
    chk({tag, " width"}, l1, exp_w * TK - 1);
    chk("R4 alternation", (s0 != s1) ? 1 : 0, 1);
  endtask

  task automatic t_midchange();
    int s0, t0, l0, s1, t1, l1, s2, t2, l2;
    test_req = 0; run_sel = 0; wid_sel = 0;
    pulse(s0, t0, l0);
    wait_rise(20000, s0, t0);
    run_sel = 1; wid_sel = 3;
    measure(s0, l0);
    pulse(s1, t1, l1); pulse(s2, t2, l2);
    chk("R8 pulse in progress keeps width", l0, 4 * TK - 1);
    chk("R8 period in progress keeps length", t1 - t0, 32 * TK);
    chk("R8 new width after boundary", l1, 12 * TK - 1);
    chk("R8 new period after boundary", t2 - t1, 64 * TK);
  endtask

  task automatic t_error_flag();
    test_req = 0; run_sel = 0; wid_sel = 2; #1;
    chk("R9 32 ticks vs 8 ticks illegal", config_error, 1);
    wid_sel = 1; #1;
    chk("R9 32 ticks vs 6 ticks legal", config_error, 0);
    run_sel = 5; #1;
    chk("R9 run code out of range", config_error, 1);
    test_req = 1; tst_sel = 3; #1;
    chk("R9 test code out of range", config_error, 1);
    tst_sel = 0; run_sel = 0; wid_sel = 3; #1;
    chk("R9 test 64 ticks vs 12 ticks legal", config_error, 0);
    test_req = 0; #1;
    chk("R9 run 32 ticks vs 12 ticks illegal", config_error, 1);
    wid_sel = 0;
  endtask

  task automatic t_illegal();
    int s0, t0, l0, s1, t1, l1;
    test_req = 0; run_sel = 0; wid_sel = 0;
    pulse(s0, t0, l0); pulse(s0, t0, l0);
    wid_sel = 2;
    wait_rise(32 * TK * 4, s1, t1);
    chk("R10 no pulse while illegal", s1, 0);
    wid_sel = 0;
    pulse(s1, t1, l1);
    chk("R10 direction held across silent periods", (s1 != s0 && s1 != 0) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_cfg("R2 sel1/R3 sel1", 0, 1, 0, 1, 64, 6);
    t_cfg("R2 sel2/R3 sel3", 0, 2, 0, 3, 128, 12);
    t_cfg("R2 sel3/R3 sel2", 0, 3, 0, 2, 512, 8);
    t_cfg("R7 test sel2", 1, 0, 2, 0, 256, 4);
    t_cfg("R7 test sel0 wid kept", 1, 0, 0, 3, 64, 12);
    t_cfg("R7 test sel1", 1, 0, 1, 1, 128, 6);
    t_midchange();
    t_error_flag();
    t_illegal();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule